// File: doc/BRIEF.md
# Privilege Mode and Stack Pointer Controller

This block holds a processor's privilege state as two status bits: a supervisor bit and a master bit. It moves between four named states according to three kinds of request: exception entry, a status-register write (move, AND, OR or XOR form), and return from exception. From the current state it derives two results. The first is the stack pointer that a register-7 access should reach. The second is the 3-bit function code that goes out with every program or data bus cycle.

The states are `PS_USER_INT` (S=0, M=0), `PS_USER_MST` (S=0, M=1), `PS_SUP_INT` (S=1, M=0) and `PS_SUP_MST` (S=1, M=1). The state code is exactly {S, M}.

There are three kinds of transition:

- **Exception entry** moves any state to a supervisor state. An interrupt arriving with M=1 lands in `PS_SUP_INT`. Any other entry keeps M.
- **Status write** moves a supervisor state to the state given by the operation result.
- **Return from exception** moves a supervisor state to the state given by the restored S and M bits.

A user state leaves only through exception entry. A status write or return made from a user state leaves the state as it is and raises a privilege-violation pulse. The pre-entry S and M bits are captured at every exception entry so that they can be stacked. Every accepted write or return produces a refill pulse, which means the pipeline is flushed.

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset, S is 1, M is 0, and both the refill and violation pulses are 0.
- R2: When `exc_req` is high, S is 1 on the next cycle. `snap_s`/`snap_m` then show the S and M values from before the entry, and they hold those values until the next entry.
- R3: On exception entry with `exc_is_irq`=1 and M=1, M becomes 0. On any other entry, M keeps its value.
- R4: While S is 0, S can become 1 only through exception entry. Exception entry has priority over a status write or return requested in the same cycle.
- R5: A status write or return requested while S=0, with no exception entry in that cycle, leaves S and M unchanged and raises `priv_viol` for exactly the next cycle.
- R6: A status write or return accepted while S=1 raises `refill` for the next cycle only. It is 0 after a cycle that had no accepted request.
- R7: A status write applies `sr_op` to both S and M, using the write's data bits as the operand. The codes are 0=move, 1=AND, 2=OR, 3=XOR.
- R8: A return loads S and M from `rte_s`/`rte_m`. A return takes priority over a status write in the same cycle.
- R9: `fc` is 3'b001 for user data, 3'b010 for user program, 3'b101 for supervisor data and 3'b110 for supervisor program. `acc_prog`=1 marks a program cycle.
- R10: `sp_sel` is 0 (user pointer) while S=0. While S=1 it is 1 (interrupt pointer) when M=0 and 2 (master pointer) when M=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception entry strobe |
| exc_is_irq | input | 1 | The entry is an interrupt |
| sr_wr | input | 1 | Status-register write strobe |
| sr_op | input | 2 | Write operation: 0 move, 1 AND, 2 OR, 3 XOR |
| sr_s_val | input | 1 | Write operand for S |
| sr_m_val | input | 1 | Write operand for M |
| rte_req | input | 1 | Return-from-exception strobe |
| rte_s | input | 1 | Restored S |
| rte_m | input | 1 | Restored M |
| acc_prog | input | 1 | Current bus cycle is a program fetch |
| s_bit | output | 1 | Current supervisor bit |
| m_bit | output | 1 | Current master bit |
| sp_sel | output | 2 | Active stack pointer select |
| fc | output | 3 | Bus function code |
| refill | output | 1 | Pipeline flush/refill pulse |
| priv_viol | output | 1 | Privilege violation pulse |
| snap_s | output | 1 | S captured at last exception entry |
| snap_m | output | 1 | M captured at last exception entry |

## Verification
The bench targets these corner cases:

- **Interrupt entry with M=1, and non-interrupt entry from a user state that has M=1.** A design that clears M on every entry would select the wrong stack pointer.
- **Status writes and returns made at user level.** A design without the privilege gate would escape to supervisor or skip the violation pulse.
- **Colliding strobes.** Exception entry plus write, and return plus write, arrive in the same cycle. Wrong priority shows up as the wrong final S and M values or a stray refill.
- **The AND, OR and XOR forms, and function codes in both privilege levels.** These expose a swapped operation or a swapped code bit.

// File: rtl/priv_pkg.sv
package priv_pkg;
    localparam int FC_W  = 3;
    localparam int SEL_W = 2;
    localparam int OP_W  = 2;

    typedef enum logic [1:0] {
        PS_USER_INT = 2'b00,
        PS_USER_MST = 2'b01,
        PS_SUP_INT  = 2'b10,
        PS_SUP_MST  = 2'b11
    } priv_state_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_EXC  = 2'd1,
        EV_RTE  = 2'd2,
        EV_SRW  = 2'd3
    } priv_ev_e;

    typedef enum logic [OP_W-1:0] {
        OP_MOVE = 2'd0,
        OP_AND  = 2'd1,
        OP_OR   = 2'd2,
        OP_XOR  = 2'd3
    } sr_op_e;

    localparam logic [SEL_W-1:0] SEL_USER = 2'd0;
    localparam logic [SEL_W-1:0] SEL_INT  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_MST  = 2'd2;
endpackage

// File: rtl/priv_sr_alu.sv
module priv_sr_alu
    import priv_pkg::*;
(
    input  logic [1:0]      cur_sm,
    input  logic [OP_W-1:0] op,
    input  logic [1:0]      operand,
    output logic [1:0]      res_sm
);
    always_comb begin
        unique case (sr_op_e'(op))
            OP_MOVE: res_sm = operand;
            OP_AND:  res_sm = cur_sm & operand;
            OP_OR:   res_sm = cur_sm | operand;
            OP_XOR:  res_sm = cur_sm ^ operand;
            default: res_sm = operand;
        endcase
    end
endmodule

// File: rtl/priv_state_fsm.sv
module priv_state_fsm
    import priv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  priv_ev_e    ev,
    input  logic        irq,
    input  logic [1:0]  load_sm,
    output priv_state_e state
);
    priv_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_SUP_INT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_USER_INT: begin
                if (ev == EV_EXC) state_nx = PS_SUP_INT;
            end
            PS_USER_MST: begin
                if (ev == EV_EXC) state_nx = irq ? PS_SUP_INT : PS_SUP_MST;
            end
            PS_SUP_INT: begin
                if (ev == EV_EXC)                       state_nx = PS_SUP_INT;
                else if (ev == EV_RTE || ev == EV_SRW)  state_nx = priv_state_e'(load_sm);
            end
            PS_SUP_MST: begin
                if (ev == EV_EXC)                       state_nx = irq ? PS_SUP_INT : PS_SUP_MST;
                else if (ev == EV_RTE || ev == EV_SRW)  state_nx = priv_state_e'(load_sm);
            end
            default: state_nx = PS_SUP_INT;
        endcase
    end
endmodule

// File: rtl/priv_bus_map.sv
module priv_bus_map
    import priv_pkg::*;
(
    input  priv_state_e       state,
    input  logic              prog,
    output logic [FC_W-1:0]   fc,
    output logic [SEL_W-1:0]  sp_sel
);
    always_comb begin
        unique case (state)
            PS_USER_INT, PS_USER_MST: begin
                sp_sel = SEL_USER;
                fc     = prog ? 3'b010 : 3'b001;
            end
            PS_SUP_INT: begin
                sp_sel = SEL_INT;
                fc     = prog ? 3'b110 : 3'b101;
            end
            PS_SUP_MST: begin
                sp_sel = SEL_MST;
                fc     = prog ? 3'b110 : 3'b101;
            end
            default: begin
                sp_sel = SEL_INT;
                fc     = 3'b101;
            end
        endcase
    end
endmodule

// File: rtl/priv_event_regs.sv
module priv_event_regs
    import priv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  priv_ev_e ev,
    input  logic     viol_req,
    input  logic [1:0] cur_sm,
    output logic     refill,
    output logic     viol,
    output logic [1:0] snap_sm
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refill  <= 1'b0;
            viol    <= 1'b0;
            snap_sm <= 2'b10;
        end else begin
            refill <= (ev == EV_RTE) || (ev == EV_SRW);
            viol   <= viol_req;
            if (ev == EV_EXC) snap_sm <= cur_sm;
        end
    end
endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
    import priv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        exc_req,
    input  logic        exc_is_irq,
    input  logic        sr_wr,
    input  logic [1:0]  sr_op,
    input  logic        sr_s_val,
    input  logic        sr_m_val,
    input  logic        rte_req,
    input  logic        rte_s,
    input  logic        rte_m,
    input  logic        acc_prog,
    output logic        s_bit,
    output logic        m_bit,
    output logic [1:0]  sp_sel,
    output logic [2:0]  fc,
    output logic        refill,
    output logic        priv_viol,
    output logic        snap_s,
    output logic        snap_m
);
    priv_state_e state;
    priv_ev_e    ev;
    logic [1:0]  cur_sm, alu_sm, load_sm, snap_sm;
    logic        viol_req;

    assign cur_sm = state;
    assign s_bit  = cur_sm[1];
    assign m_bit  = cur_sm[0];

    always_comb begin
        ev       = EV_NONE;
        viol_req = 1'b0;
        if (exc_req)                  ev = EV_EXC;
        else if (rte_req || sr_wr) begin
            if (!s_bit)               viol_req = 1'b1;
            else if (rte_req)         ev = EV_RTE;
            else                      ev = EV_SRW;
        end
    end

    priv_sr_alu u_alu (
        .cur_sm (cur_sm),
        .op     (sr_op),
        .operand({sr_s_val, sr_m_val}),
        .res_sm (alu_sm)
    );

    assign load_sm = (ev == EV_RTE) ? {rte_s, rte_m} : alu_sm;

    priv_state_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .irq    (exc_is_irq),
        .load_sm(load_sm),
        .state  (state)
    );

    priv_bus_map u_map (
        .state (state),
        .prog  (acc_prog),
        .fc    (fc),
        .sp_sel(sp_sel)
    );

    priv_event_regs u_evr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .viol_req(viol_req),
        .cur_sm  (cur_sm),
        .refill  (refill),
        .viol    (priv_viol),
        .snap_sm (snap_sm)
    );

    assign snap_s = snap_sm[1];
    assign snap_m = snap_sm[0];
endmodule

// File: rtl/priv_mode_chk.sv
module priv_mode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       exc_req,
    input logic       exc_is_irq,
    input logic       sr_wr,
    input logic       rte_req,
    input logic       acc_prog,
    input logic       s_bit,
    input logic       m_bit,
    input logic [1:0] sp_sel,
    input logic [2:0] fc,
    input logic       refill,
    input logic       priv_viol
);
    p_exc_sets_s_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> s_bit);

    p_irq_clears_m_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_is_irq && m_bit) |=> !m_bit);

    p_other_keeps_m_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !exc_is_irq) |=> (m_bit == $past(m_bit)));

    p_user_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_bit && !exc_req) |=> !s_bit);

    p_user_viol_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_bit && !exc_req && (sr_wr || rte_req)) |=> (priv_viol && $stable(m_bit)));

    p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bit && !exc_req && (sr_wr || rte_req)) |=> refill);

    p_no_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req || !(sr_wr || rte_req)) |=> !refill);

    p_fc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fc[2] == s_bit) && (fc[1] == acc_prog) && (fc[0] == !acc_prog));

    p_sp_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sp_sel == (!s_bit ? 2'd0 : (m_bit ? 2'd2 : 2'd1)));
endmodule

bind priv_mode_ctrl priv_mode_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_req   (exc_req),
    .exc_is_irq(exc_is_irq),
    .sr_wr     (sr_wr),
    .rte_req   (rte_req),
    .acc_prog  (acc_prog),
    .s_bit     (s_bit),
    .m_bit     (m_bit),
    .sp_sel    (sp_sel),
    .fc        (fc),
    .refill    (refill),
    .priv_viol (priv_viol)
);

// File: tb/test_priv_mode_ctrl.sv
`timescale 1ns/1ps
module test_priv_mode_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exc_req = 0, exc_is_irq = 0, sr_wr = 0, sr_s_val = 0, sr_m_val = 0;
    logic rte_req = 0, rte_s = 0, rte_m = 0, acc_prog = 0;
    logic [1:0] sr_op = 0;
    logic s_bit, m_bit, refill, priv_viol, snap_s, snap_m;
    logic [1:0] sp_sel;
    logic [2:0] fc;

    always #2.5 clk = ~clk;

    priv_mode_ctrl i_priv_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_is_irq(exc_is_irq),
        .sr_wr(sr_wr), .sr_op(sr_op), .sr_s_val(sr_s_val), .sr_m_val(sr_m_val),
        .rte_req(rte_req), .rte_s(rte_s), .rte_m(rte_m), .acc_prog(acc_prog),
        .s_bit(s_bit), .m_bit(m_bit), .sp_sel(sp_sel), .fc(fc), .refill(refill),
        .priv_viol(priv_viol), .snap_s(snap_s), .snap_m(snap_m)
    );

    typedef struct {
        logic [1:0] sm;
        logic       rf;
        logic       vl;
        logic [1:0] snap;
        logic [2:0] fc;
        logic [1:0] sp;
        string      tag;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    logic ms = 1'b1, mm = 1'b0;
    logic [1:0] esnap = 2'b10;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic exc, input logic irq, input logic srw, input logic [1:0] op,
                        input logic sv, input logic mv, input logic rte, input logic rs,
                        input logic rm, input logic prog, input string tag);
        exp_t e;
        logic [1:0] o;
        @(negedge clk);
        exc_req = exc; exc_is_irq = irq; sr_wr = srw; sr_op = op; sr_s_val = sv;
        sr_m_val = mv; rte_req = rte; rte_s = rs; rte_m = rm; acc_prog = prog;
        e.rf = 0; e.vl = 0;
        if (exc) begin
            esnap = {ms, mm};
            if (irq && mm) mm = 0;
            ms = 1;
        end else if (rte || srw) begin
            if (!ms) e.vl = 1;
            else if (rte) begin {ms, mm} = {rs, rm}; e.rf = 1; end
            else begin
                o = {sv, mv};
                case (op)
                    2'd0: {ms, mm} = o;
                    2'd1: {ms, mm} = {ms, mm} & o;
                    2'd2: {ms, mm} = {ms, mm} | o;
                    default: {ms, mm} = {ms, mm} ^ o;
                endcase
                e.rf = 1;
            end
        end
        e.sm = {ms, mm};
        e.snap = esnap;
        e.fc = {ms, prog, !prog};
        e.sp = !ms ? 2'd0 : (mm ? 2'd2 : 2'd1);
        e.tag = tag;
        q.push_back(e);
        @(posedge clk);
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " S/M"}, {14'd0, s_bit, m_bit}, {14'd0, e.sm});
            check({e.tag, " refill"}, {15'd0, refill}, {15'd0, e.rf});
            check({e.tag, " viol"}, {15'd0, priv_viol}, {15'd0, e.vl});
            check({e.tag, " snap"}, {14'd0, snap_s, snap_m}, {14'd0, e.snap});
            check({e.tag, " fc R9"}, {13'd0, fc}, {13'd0, e.fc});
            check({e.tag, " sp_sel R10"}, {14'd0, sp_sel}, {14'd0, e.sp});
        end
    end

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset S/M", {14'd0, s_bit, m_bit}, 16'h2);
        check("R1 reset pulses", {14'd0, refill, priv_viol}, 16'h0);
        check("R10 reset sp_sel", {14'd0, sp_sel}, 16'h1);
        @(negedge clk); rst_n = 1;
        //        exc irq srw op sv mv rte rs rm prog
        step(0,0,0,0,0,0,0,0,0,1, "R9 idle sup prog");
        step(0,0,1,0,1,1,0,0,0,0, "R7 move to master");
        step(0,0,0,0,0,0,0,0,0,0, "R6 refill single");
        step(1,1,0,0,0,0,0,0,0,0, "R3 irq clears M");
        step(0,0,1,2,0,1,0,0,0,0, "R7 OR sets M");
        step(1,0,0,0,0,0,0,0,0,1, "R3 non-irq keeps M");
        step(0,0,1,0,0,1,0,0,0,0, "R7 move to user master");
        step(0,0,0,0,0,0,0,0,0,1, "R9 user prog");
        step(0,0,0,0,0,0,0,0,0,0, "R9 user data");
        step(0,0,1,0,1,1,0,0,0,0, "R5 write at user");
        step(0,0,0,0,0,0,1,1,1,0, "R5 rte at user");
        step(0,0,0,0,0,0,0,0,0,0, "R5 viol single");
        step(1,0,0,0,0,0,0,0,0,0, "R2 entry from user master");
        step(0,0,1,1,1,0,0,0,0,0, "R7 AND clears M");
        step(0,0,1,3,1,1,0,0,0,0, "R7 XOR to user master");
        step(1,1,1,0,0,0,0,0,0,0, "R4 exc beats write");
        step(0,0,1,3,0,1,0,0,0,1, "R7 XOR sets M");
        step(0,0,1,0,1,0,1,0,0,0, "R8 rte beats write to user");
        step(1,0,1,0,0,1,1,0,1,0, "R4 exc beats rte");
        step(0,0,0,0,0,0,1,1,1,1, "R8 rte to master");
        step(1,1,0,0,0,0,0,0,0,0, "R2 snapshot master");
        step(0,0,0,0,0,0,0,0,0,0, "R6 idle no refill");
        repeat (2) @(posedge clk);
        #2;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule